// File: doc/BRIEF.md
# Delay-Locked Loop Lock and Impedance Update Sequencer

This block supplies the digital side of a delay-locked loop. It runs on a free-running reference clock. A one-cycle event pulse arrives for each rising edge of the monitored input clock, and the block times the period between events in reference cycles. Lock is declared only after an unbroken run of acceptable periods. A clock that slows below the minimum supported frequency, or that stops for longer than a gap threshold, clears the lock and restarts the run on its own, with no reset needed. An enable pin held low keeps the loop off. While it is low the lock flag stays low and no counting takes place.

Separately from the lock state, a free-running timer issues a single-cycle impedance update strobe at a fixed interval after reset. The recalibration logic downstream uses it to follow supply and temperature drift.

The limits come from parameters. The reference period is in picoseconds, the stop gap is in nanoseconds and the lowest supported input frequency is in MHz. The required run length and the update interval are given in cycles. From these the block derives the gap limit GAP = ceil(GAP_NS·1000 / REF_PERIOD_PS), which is 8 by default. It also derives the slow limit SLOW = floor((10^6 / MIN_FREQ_MHZ) / REF_PERIOD_PS), which is 3 by default.

Top module: `dllseq_top`

## Requirements
- R1: Lock rises after LOCK_CYCLES (default 1024) consecutive good periods. `locked_o` goes high at the reference edge that samples the event ending the LOCK_CYCLES-th good period. The first event after reset, a stop, a slow period or re-enable only starts timing and does not count.
- R2: A period is good when it is at most SLOW reference cycles long, and slow when it is longer. With the default parameters a 3-cycle period is good and a 4-cycle period is slow.
- R3: An event that ends a slow period clears `locked_o` at the edge that samples it and restarts the run from zero. Any partial count is discarded.
- R4: After the last sampled event, if GAP consecutive reference cycles pass with no event, `locked_o` clears at the GAP-th following edge. It is still high one edge earlier.
- R5: No reset is needed to regain lock. After a stop, a steady clock locks again under the rule in R1.
- R6: While `dll_on_i` is low, `locked_o` is low from the edge that samples the low level, and events are not counted. After `dll_on_i` returns high, the first event does not count.
- R7: `zq_upd_o` is a single-cycle pulse. It is first high during the cycle that follows the ZQ_INTERVAL-th active edge after internal reset release, and then every ZQ_INTERVAL cycles. It does not depend on `dll_on_i` or on the lock state.
- R8: While `rst_ni` is low, both outputs are low. Internal reset releases at the second reference edge after `rst_ni` rises.
- R9: `kedge_i` is high for exactly one reference cycle per rising edge of the monitored clock, synchronous to `clk_ref_i`. `dll_on_i` is also synchronous to `clk_ref_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| kedge_i | input | 1 | One-cycle pulse per monitored clock edge |
| dll_on_i | input | 1 | Loop enable; low turns the loop off |
| locked_o | output | 1 | Lock flag |
| zq_upd_o | output | 1 | Single-cycle impedance update strobe |

## Verification
Every result is a single register stage away from the edge that samples its cause. A lock rise or a slow fault shows after the very edge that samples the event. The enable going low shows after the edge that samples it, and a stop shows GAP edges after the last event. The update strobe shows after edge 2 + k·ZQ_INTERVAL counted from reset release. The driver works out the index of the edge for each expected lock change before it drives the stimulus. It queues one entry for the change and one for the edge before, so an error of one cycle in either direction fails. The monitor samples 1 ns after each edge, compares the entry whose index matches, and checks the strobe on every cycle against its formula.

// File: rtl/dllseq_pkg.sv
package dllseq_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SLOW = 2'd1,
    FLT_STOP = 2'd2,
    FLT_OFF  = 2'd3
  } fault_e;

  // reference cycles that cover the stop gap, rounded up
  function automatic int gap_cycles(input int ref_ps, input int gap_ns);
    return (gap_ns * 1000 + ref_ps - 1) / ref_ps;
  endfunction

  // longest acceptable input period in whole reference cycles
  function automatic int slow_cycles(input int ref_ps, input int fmin_mhz);
    return (1000000 / fmin_mhz) / ref_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dllseq_rst_sync.sv
module dllseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/dllseq_gap_mon.sv
module dllseq_gap_mon
  import dllseq_pkg::*;
#(
  parameter int GAP_LIM  = 8,
  parameter int SLOW_LIM = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   kedge_i,
  output fault_e fault_o,
  output logic   good_o
);
  localparam int SAT = max2(GAP_LIM, SLOW_LIM);
  localparam int SW  = $clog2(SAT + 1);
  localparam logic [SW-1:0] SAT_V  = SW'(SAT);
  localparam logic [SW-1:0] SLOW_V = SW'(SLOW_LIM);
  localparam logic [SW-1:0] STOP_V = SW'(GAP_LIM - 1);

  logic [SW-1:0] since_q, since_d;
  logic          since_en;

  // cycles since the last event, saturating; held saturated while off
  always_comb begin
    since_en = !en_i || kedge_i || (since_q != SAT_V);
    if (!en_i)        since_d = SAT_V;
    else if (kedge_i) since_d = '0;
    else              since_d = since_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       since_q <= SAT_V;
    else if (since_en) since_q <= since_d;
  end

  always_comb begin
    if (!en_i)                              fault_o = FLT_OFF;
    else if (kedge_i && since_q >= SLOW_V)  fault_o = FLT_SLOW;
    else if (!kedge_i && since_q >= STOP_V) fault_o = FLT_STOP;
    else                                    fault_o = FLT_NONE;
    good_o = en_i && kedge_i && (since_q < SLOW_V);
  end
endmodule

// File: rtl/dllseq_lock_ctr.sv
module dllseq_lock_ctr
  import dllseq_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  fault_e fault_i,
  input  logic   good_i,
  output logic   locked_o
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST_V = CW'(LOCK_CYCLES - 1);
  localparam logic [CW-1:0] FULL_V = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en, lock_en, lock_d, lock_q, flt;

  always_comb begin
    flt     = (fault_i != FLT_NONE);
    cnt_en  = flt || (good_i && cnt_q != FULL_V);
    cnt_d   = flt ? '0 : cnt_q + 1'b1;
    lock_en = flt || (good_i && cnt_q == LAST_V);
    lock_d  = !flt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (lock_en) lock_q <= lock_d;
    end
  end

  assign locked_o = lock_q;
endmodule

// File: rtl/dllseq_zq_timer.sv
module dllseq_zq_timer #(
  parameter int INTERVAL = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic upd_o
);
  localparam int ZW = $clog2(INTERVAL);
  localparam logic [ZW-1:0] LAST_V = ZW'(INTERVAL - 1);

  logic [ZW-1:0] cnt_q, cnt_d;
  logic          wrap, upd_q;

  always_comb begin
    wrap  = (cnt_q == LAST_V);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      upd_q <= wrap;
    end
  end

  assign upd_o = upd_q;
endmodule

// File: rtl/dllseq_top.sv
module dllseq_top
  import dllseq_pkg::*;
#(
  parameter int REF_PERIOD_PS = 4000,
  parameter int GAP_NS        = 30,
  parameter int MIN_FREQ_MHZ  = 80,
  parameter int LOCK_CYCLES   = 1024,
  parameter int ZQ_INTERVAL   = 1024
) (
  input  logic clk_ref_i,
  input  logic rst_ni,
  input  logic kedge_i,
  input  logic dll_on_i,
  output logic locked_o,
  output logic zq_upd_o
);
  localparam int GAP_LIM  = gap_cycles(REF_PERIOD_PS, GAP_NS);
  localparam int SLOW_LIM = slow_cycles(REF_PERIOD_PS, MIN_FREQ_MHZ);

  logic   rst_sync_n;
  fault_e fault;
  logic   good;

  dllseq_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_ref_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  dllseq_gap_mon #(.GAP_LIM(GAP_LIM), .SLOW_LIM(SLOW_LIM)) u_gap (
    .clk_i  (clk_ref_i),
    .rst_ni (rst_sync_n),
    .en_i   (dll_on_i),
    .kedge_i(kedge_i),
    .fault_o(fault),
    .good_o (good)
  );

  dllseq_lock_ctr #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i   (clk_ref_i),
    .rst_ni  (rst_sync_n),
    .fault_i (fault),
    .good_i  (good),
    .locked_o(locked_o)
  );

  dllseq_zq_timer #(.INTERVAL(ZQ_INTERVAL)) u_zq (
    .clk_i (clk_ref_i),
    .rst_ni(rst_sync_n),
    .upd_o (zq_upd_o)
  );
endmodule

// File: rtl/dllseq_chk.sv
module dllseq_chk #(
  parameter int GAP_LIM  = 8,
  parameter int SLOW_LIM = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic kedge_i,
  input logic dll_on_i,
  input logic locked_i,
  input logic zq_i
);
  localparam int SAT = (GAP_LIM > SLOW_LIM) ? GAP_LIM : SLOW_LIM;
  localparam int W   = $clog2(SAT + 1);

  logic [W-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   idle_q <= W'(SAT);
    else if (kedge_i)              idle_q <= '0;
    else if (idle_q != W'(SAT))    idle_q <= idle_q + 1'b1;
  end

  // R1
  lock_on_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_i) |-> $past(kedge_i));

  // R3
  slow_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kedge_i && idle_q >= W'(SLOW_LIM)) |=> !locked_i);

  // R4
  stop_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q >= W'(GAP_LIM)) |-> !locked_i);

  // R6
  off_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dll_on_i |=> !locked_i);

  // R6
  lock_needs_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_i) |-> $past(dll_on_i));

  // R7
  zq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zq_i |=> !zq_i);
endmodule

bind dllseq_top dllseq_chk #(.GAP_LIM(GAP_LIM), .SLOW_LIM(SLOW_LIM)) u_chk (
  .clk_i   (clk_ref_i),
  .rst_ni  (rst_sync_n),
  .kedge_i (kedge_i),
  .dll_on_i(dll_on_i),
  .locked_i(locked_o),
  .zq_i    (zq_upd_o)
);

// File: tb/sim_dllseq_top.sv
module sim_dllseq_top;
  localparam int GAP  = (30 * 1000 + 4000 - 1) / 4000;  // 8
  localparam int LOCK = 1024;
  localparam int ZQI  = 1024;

  logic clk = 1'b0, rst_n = 1'b0, kedge = 1'b0, dll_on = 1'b1;
  logic locked, zq;

  always #2 clk = ~clk;

  dllseq_top u0 (
    .clk_ref_i(clk), .rst_ni(rst_n), .kedge_i(kedge),
    .dll_on_i(dll_on), .locked_o(locked), .zq_upd_o(zq)
  );

  int cyc = 0, n_chk = 0, n_err = 0, last_s = 0;
  bit done = 0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  typedef struct { int at; logic val; string req; } exp_t;
  exp_t q[$];

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic push(int at, logic v, string req);
    exp_t e; e.at = at; e.val = v; e.req = req; q.push_back(e);
  endtask

  // monitor: 1 ns after each edge
  initial forever begin
    @(posedge clk); #1;
    if (rst_n && !done) begin
      while (q.size() > 0 && q[0].at < cyc) begin
        n_chk++; n_err++;
        $display("FAIL %s: check at cycle %0d missed, got - expected %b", q[0].req, q[0].at, q[0].val);
        void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].at == cyc) begin
        chk(q[0].req, locked, q[0].val);
        void'(q.pop_front());
      end
      // R7: pulse after edge 2 + k*ZQI counted from reset release
      chk("R7", zq, (cyc >= ZQI + 2) && ((cyc - 2) % ZQI == 0));
    end
  end

  // R9: one-cycle event pulse, driven at the falling edge
  task automatic tick(logic k);
    kedge = k;
    @(negedge clk);
    if (k) last_s = cyc;
    kedge = 1'b0;
  endtask

  task automatic train(int period, int n, bit first_counts, bit expect_lock, string req);
    int base = cyc;
    int li = first_counts ? LOCK - 1 : LOCK;
    if (expect_lock && n > li) begin
      push(base + (li + 1) * period - 1, 1'b0, req);
      push(base + (li + 1) * period, 1'b1, req);
    end else begin
      push(base + n * period, 1'b0, req);
    end
    for (int i = 0; i < n; i++) begin
      for (int j = 0; j < period - 1; j++) tick(1'b0);
      tick(1'b1);
    end
  endtask

  initial begin
    #(4 * 190000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", locked, 1'b0);
    chk("R8", zq, 1'b0);
    rst_n = 1'b1;
    repeat (4) tick(1'b0);

    // R1 / R2: period 3 is good, first event only starts timing
    train(3, LOCK + 1, 0, 1, "R1");

    // R4: stop the clock
    push(last_s + GAP - 1, 1'b1, "R4");
    push(last_s + GAP, 1'b0, "R4");
    repeat (GAP + 4) tick(1'b0);

    // R5: relock with no reset
    train(3, LOCK + 1, 0, 1, "R5");

    // R3: one slow period drops lock
    push(cyc + 4, 1'b1, "R3");
    push(cyc + 5, 1'b0, "R3");
    repeat (4) tick(1'b0);
    tick(1'b1);

    // R2: period 4 never locks
    train(4, LOCK + 5, 0, 0, "R2");

    // R3: partial run discarded by a slow period
    train(3, LOCK / 2, 1, 0, "R3");
    push(cyc + 4, 1'b0, "R3");
    repeat (3) tick(1'b0);
    tick(1'b1);
    train(3, LOCK, 1, 1, "R3");

    // R6: disable while locked
    chk("R6", locked, 1'b1);
    push(cyc + 1, 1'b0, "R6");
    dll_on = 1'b0;
    tick(1'b0);
    train(3, LOCK + 5, 1, 0, "R6");
    dll_on = 1'b1;
    tick(1'b0);
    train(3, LOCK + 1, 0, 1, "R6");

    repeat (10) tick(1'b0);
    done = 1;
    if (q.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL R1: got %0d pending checks expected 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule